// File: doc/BRIEF.md
# Sound Unit Control Register Bank

This block holds the control state of a four-channel sound unit behind an 8-bit memory-mapped port. Each write lands in one of twenty channel and mixer registers or in a master register that carries the power switch. The stored contents are broken out into decoded fields, such as frequency, duty, length, envelope and trigger, which drive the channel engines. Those engines sit outside this block.

Reads are registered and return in the cycle after the address is presented. Bits that have no read path come back as 1, because every register has a fixed readback mask that is ORed into its stored value. The master switch gates the whole bank. Turning it off clears every channel and mixer register in the same edge, and while it stays off, writes to those registers are dropped. The exception is the older model style, selected by `style_old`, in which the length fields can still be loaded while power is off.

Top module: `snd_reg_bank`

## Requirements
- R1: After reset the bank reads: offset 0 as 0x80, offset 18 (volume) as 0x77, offset 19 (panning) as 0xF3, and offset 20 (master) as 0xF0 ORed with `ch_active`. Power is on after reset.
- R2: A read of any offset from 0 to 19 returns the stored byte ORed with that offset's mask. The masks for offsets 0..19 are 80,3F,00,FF,BF,3F,00,FF,BF,7F,FF,9F,FF,BF,FF,00,00,BF,00,00 (hex).
- R3: The following offsets are write-only and read 0xFF: the frequency-low offsets 3, 7 and 12, and the length offsets 10 and 14. The trigger/high offsets 4, 8, 13 and 17 expose only bit 6 (length enable), so they read 0xBF or 0xFF.
- R4: A write to offset 20 keeps only bit 7 as power. A read of offset 20 returns {power, 3'b111, ch_active[3:0]}.
- R5: A master write that turns power from 1 to 0 clears all registers at offsets 0..19 to 0 on that same clock edge.
- R6: While power is off, writes to offsets 0..19 change nothing, and each of those offsets reads as its mask alone. The only exceptions are the R7 and R8 cases.
- R7: With `style_old`=1 and power off, writes to offset 10 (wave length) and offset 14 (noise length) are stored in full.
- R8: With `style_old`=1 and power off, writes to offset 1 or offset 5 (pulse duty/length) store only bits 5:0. The duty field, bits 7:6, stays 0.
- R9: Offsets 21..31 read 0xFF, and writes to them leave every output unchanged.
- R10: A powered write with bit 7 set to a trigger offset gives a one-cycle pulse, starting the next cycle, on that channel's trigger output. The trigger offsets are 4 (ch1), 8 (ch2), 13 (ch3) and 17 (ch4). No pulse occurs while power is off.
- R11: `rdata` presents the addressed value one clock after `addr`.
- R12: The fields decode as follows.
  - Frequency is {high[2:0], low[7:0]}.
  - Length enable is bit 6 of the trigger/high byte.
  - Duty is bits 7:6 and length is bits 5:0 of the duty/length byte.
  - Sweep is bits 6:0 of offset 0.
  - The channel 3 DAC enable is bit 7 of offset 9, and its level is bits 6:5 of offset 11.
  - The noise length is bits 5:0 of offset 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| style_old | input | 1 | 1 selects the older model's power-off length rules |
| ch_active | input | 4 | Channel running flags, bit 0 is ch1 |
| rdata | output | 8 | Registered read data |
| power_on | output | 1 | Master power |
| ch1_sweep | output | 7 | Ch1 sweep control |
| ch1_duty | output | 2 | Ch1 duty |
| ch1_len | output | 6 | Ch1 length load |
| ch1_env | output | 8 | Ch1 envelope |
| ch1_freq | output | 11 | Ch1 frequency |
| ch1_len_en | output | 1 | Ch1 length enable |
| ch1_trig | output | 1 | Ch1 trigger pulse |
| ch2_duty | output | 2 | Ch2 duty |
| ch2_len | output | 6 | Ch2 length load |
| ch2_env | output | 8 | Ch2 envelope |
| ch2_freq | output | 11 | Ch2 frequency |
| ch2_len_en | output | 1 | Ch2 length enable |
| ch2_trig | output | 1 | Ch2 trigger pulse |
| ch3_dac_en | output | 1 | Ch3 DAC enable |
| ch3_len | output | 8 | Ch3 length load |
| ch3_level | output | 2 | Ch3 output level |
| ch3_freq | output | 11 | Ch3 frequency |
| ch3_len_en | output | 1 | Ch3 length enable |
| ch3_trig | output | 1 | Ch3 trigger pulse |
| ch4_len | output | 6 | Ch4 length load |
| ch4_env | output | 8 | Ch4 envelope |
| ch4_poly | output | 8 | Ch4 noise shape |
| ch4_len_en | output | 1 | Ch4 length enable |
| ch4_trig | output | 1 | Ch4 trigger pulse |
| mix_vol | output | 8 | Master volume byte |
| mix_pan | output | 8 | Panning byte |

## Verification
The assertions check the following on every cycle:
- the layout of the master read;
- the 0xFF result for unmapped offsets;
- the mask-only readback and the absence of trigger pulses while power is off;
- the clearing of the fields on the edge where power falls;
- that at most one trigger fires per cycle.

Three behaviours depend on what was written earlier, so only the bench scenarios can show them. These are the style-dependent length loads made while power is off, the reset contents, and the decoding of fields after random write streams. The bench compares every output field and every read against a reference model of the bank.

// File: rtl/snd_bank_pkg.sv
package snd_bank_pkg;

  localparam int DW        = 8;
  localparam int NUM_REGS  = 20;
  localparam int MASTER_IX = 20;

  // offsets whose behaviour neighbours depend on
  localparam int C1_SWEEP = 0;
  localparam int C1_DL    = 1;
  localparam int C1_ENV   = 2;
  localparam int C1_FLO   = 3;
  localparam int C1_FHI   = 4;
  localparam int C2_DL    = 5;
  localparam int C2_ENV   = 6;
  localparam int C2_FLO   = 7;
  localparam int C2_FHI   = 8;
  localparam int C3_EN    = 9;
  localparam int C3_LEN   = 10;
  localparam int C3_LVL   = 11;
  localparam int C3_FLO   = 12;
  localparam int C3_FHI   = 13;
  localparam int C4_LEN   = 14;
  localparam int C4_ENV   = 15;
  localparam int C4_POLY  = 16;
  localparam int C4_CTL   = 17;
  localparam int MX_VOL   = 18;
  localparam int MX_PAN   = 19;

  localparam logic [DW-1:0] PULSE_LEN_BITS = 8'h3F;

  function automatic logic [DW-1:0] rd_mask(input int ix);
    case (ix)
      C1_SWEEP:                      return 8'h80;
      C1_DL, C2_DL:                  return 8'h3F;
      C1_FLO, C2_FLO, C3_FLO:        return 8'hFF;
      C3_LEN, C4_LEN:                return 8'hFF;
      C1_FHI, C2_FHI, C3_FHI, C4_CTL: return 8'hBF;
      C3_EN:                         return 8'h7F;
      C3_LVL:                        return 8'h9F;
      default:                       return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_val(input int ix);
    case (ix)
      C1_SWEEP:                 return 8'h80;
      C1_DL:                    return 8'hBF;
      C1_ENV, C1_FLO, MX_PAN:   return 8'hF3;
      C2_DL:                    return 8'h3F;
      C1_FHI, C2_FHI, C3_FHI, C4_CTL: return 8'hBF;
      C3_EN:                    return 8'h7F;
      C3_LEN, C4_LEN:           return 8'hFF;
      C3_LVL:                   return 8'h9F;
      MX_VOL:                   return 8'h77;
      default:                  return 8'h00;
    endcase
  endfunction

  // length registers loaded in full while power is off (older style)
  function automatic bit full_when_off(input int ix);
    return (ix == C3_LEN) || (ix == C4_LEN);
  endfunction

  // pulse duty/length registers that keep only length bits while off
  function automatic bit part_when_off(input int ix);
    return (ix == C1_DL) || (ix == C2_DL);
  endfunction

  function automatic int trig_ix(input int ch);
    case (ch)
      0:       return C1_FHI;
      1:       return C2_FHI;
      2:       return C3_FHI;
      default: return C4_CTL;
    endcase
  endfunction

endpackage

// File: rtl/snd_power_ctl.sv
module snd_power_ctl #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata_msb,
  output logic              pwr,
  output logic              pwr_fall
);
  import snd_bank_pkg::*;

  logic master_hit;

  assign master_hit = wr_en && (addr == ADDR_W'(MASTER_IX));
  assign pwr_fall   = master_hit && pwr && !wdata_msb;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr <= 1'b1;
    end else if (master_hit) begin
      pwr <= wdata_msb;
    end
  end

endmodule

// File: rtl/snd_reg_file.sv
module snd_reg_file #(
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = snd_bank_pkg::NUM_REGS
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    wr_en,
  input  logic [ADDR_W-1:0]                       addr,
  input  logic [snd_bank_pkg::DW-1:0]             wdata,
  input  logic                                    pwr,
  input  logic                                    pwr_fall,
  input  logic                                    style_old,
  output logic [NUM_REGS-1:0][snd_bank_pkg::DW-1:0] regs
);
  import snd_bank_pkg::*;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DW-1:0] RST_V = reset_val(g);
    localparam bit            FULL  = full_when_off(g);
    localparam bit            PART  = part_when_off(g);

    logic          hit;
    logic [DW-1:0] q;

    assign hit = wr_en && (addr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= RST_V;
      end else if (pwr_fall) begin
        q <= '0;
      end else if (hit) begin
        if (pwr) begin
          q <= wdata;
        end else if (style_old && FULL) begin
          q <= wdata;
        end else if (style_old && PART) begin
          q <= wdata & PULSE_LEN_BITS;
        end
      end
    end

    assign regs[g] = q;
  end

endmodule

// File: rtl/snd_readback.sv
module snd_readback #(
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = snd_bank_pkg::NUM_REGS,
  parameter int NUM_CH   = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [ADDR_W-1:0]                         addr,
  input  logic [NUM_REGS-1:0][snd_bank_pkg::DW-1:0] regs,
  input  logic                                      pwr,
  input  logic [NUM_CH-1:0]                         ch_active,
  output logic [snd_bank_pkg::DW-1:0]               rdata
);
  import snd_bank_pkg::*;

  localparam int FILL_W = DW - 1 - NUM_CH;

  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) begin
        rd_val = regs[i] | rd_mask(i);
      end
    end
    if (addr == ADDR_W'(MASTER_IX)) begin
      rd_val = {pwr, {FILL_W{1'b1}}, ch_active};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '1;
    end else begin
      rdata <= rd_val;
    end
  end

endmodule

// File: rtl/snd_trigger_gen.sv
module snd_trigger_gen #(
  parameter int ADDR_W = 5,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata_msb,
  input  logic              pwr,
  output logic [NUM_CH-1:0] trig
);
  import snd_bank_pkg::*;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int TIX = trig_ix(c);

    always_ff @(posedge clk) begin
      if (rst) begin
        trig[c] <= 1'b0;
      end else begin
        trig[c] <= wr_en && pwr && wdata_msb && (addr == ADDR_W'(TIX));
      end
    end
  end

endmodule

// File: rtl/snd_reg_bank.sv
module snd_reg_bank #(
  parameter int ADDR_W = 5,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              style_old,
  input  logic [NUM_CH-1:0] ch_active,
  output logic [7:0]        rdata,
  output logic              power_on,
  output logic [6:0]        ch1_sweep,
  output logic [1:0]        ch1_duty,
  output logic [5:0]        ch1_len,
  output logic [7:0]        ch1_env,
  output logic [10:0]       ch1_freq,
  output logic              ch1_len_en,
  output logic              ch1_trig,
  output logic [1:0]        ch2_duty,
  output logic [5:0]        ch2_len,
  output logic [7:0]        ch2_env,
  output logic [10:0]       ch2_freq,
  output logic              ch2_len_en,
  output logic              ch2_trig,
  output logic              ch3_dac_en,
  output logic [7:0]        ch3_len,
  output logic [1:0]        ch3_level,
  output logic [10:0]       ch3_freq,
  output logic              ch3_len_en,
  output logic              ch3_trig,
  output logic [5:0]        ch4_len,
  output logic [7:0]        ch4_env,
  output logic [7:0]        ch4_poly,
  output logic              ch4_len_en,
  output logic              ch4_trig,
  output logic [7:0]        mix_vol,
  output logic [7:0]        mix_pan
);
  import snd_bank_pkg::*;

  logic                          pwr;
  logic                          pwr_fall;
  logic [NUM_REGS-1:0][DW-1:0]   regs;
  logic [NUM_CH-1:0]             trig;

  snd_power_ctl #(.ADDR_W(ADDR_W)) u_pwr (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata_msb (wdata[7]),
    .pwr       (pwr),
    .pwr_fall  (pwr_fall)
  );

  snd_reg_file #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_file (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .pwr       (pwr),
    .pwr_fall  (pwr_fall),
    .style_old (style_old),
    .regs      (regs)
  );

  snd_readback #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .NUM_CH(NUM_CH)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .regs      (regs),
    .pwr       (pwr),
    .ch_active (ch_active),
    .rdata     (rdata)
  );

  snd_trigger_gen #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata_msb (wdata[7]),
    .pwr       (pwr),
    .trig      (trig)
  );

  // field decode straight from flops
  assign power_on   = pwr;
  assign ch1_sweep  = regs[C1_SWEEP][6:0];
  assign ch1_duty   = regs[C1_DL][7:6];
  assign ch1_len    = regs[C1_DL][5:0];
  assign ch1_env    = regs[C1_ENV];
  assign ch1_freq   = {regs[C1_FHI][2:0], regs[C1_FLO]};
  assign ch1_len_en = regs[C1_FHI][6];
  assign ch1_trig   = trig[0];

  assign ch2_duty   = regs[C2_DL][7:6];
  assign ch2_len    = regs[C2_DL][5:0];
  assign ch2_env    = regs[C2_ENV];
  assign ch2_freq   = {regs[C2_FHI][2:0], regs[C2_FLO]};
  assign ch2_len_en = regs[C2_FHI][6];
  assign ch2_trig   = trig[1];

  assign ch3_dac_en = regs[C3_EN][7];
  assign ch3_len    = regs[C3_LEN];
  assign ch3_level  = regs[C3_LVL][6:5];
  assign ch3_freq   = {regs[C3_FHI][2:0], regs[C3_FLO]};
  assign ch3_len_en = regs[C3_FHI][6];
  assign ch3_trig   = trig[2];

  assign ch4_len    = regs[C4_LEN][5:0];
  assign ch4_env    = regs[C4_ENV];
  assign ch4_poly   = regs[C4_POLY];
  assign ch4_len_en = regs[C4_CTL][6];
  assign ch4_trig   = trig[NUM_CH-1];

  assign mix_vol    = regs[MX_VOL];
  assign mix_pan    = regs[MX_PAN];

endmodule

// File: rtl/snd_reg_bank_chk.sv
module snd_reg_bank_chk #(
  parameter int ADDR_W = 5,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] ch_active,
  input logic [7:0]        rdata,
  input logic              power_on,
  input logic [7:0]        ch1_env,
  input logic [10:0]       ch1_freq,
  input logic [7:0]        mix_vol,
  input logic [7:0]        mix_pan,
  input logic              ch1_trig,
  input logic              ch2_trig,
  input logic              ch3_trig,
  input logic              ch4_trig
);
  import snd_bank_pkg::*;

  logic          seen_q;
  logic [7:0]    mask_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    mask_q <= 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) mask_q <= rd_mask(i);
    end
  end

  assert_master_read_R4: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(addr) == ADDR_W'(MASTER_IX)) |->
      (rdata == {$past(power_on), 3'b111, $past(ch_active)}));

  assert_unmapped_ff_R9: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(addr) > ADDR_W'(MASTER_IX)) |-> (rdata == 8'hFF));

  assert_off_mask_only_R6: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !$past(power_on) && $past(addr) < ADDR_W'(NUM_REGS)) |-> (rdata == mask_q));

  assert_fall_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $fell(power_on)) |->
      (ch1_env == 8'h00 && ch1_freq == 11'h000 && mix_vol == 8'h00 && mix_pan == 8'h00));

  assert_no_trig_off_R10: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !$past(power_on)) |-> !(ch1_trig || ch2_trig || ch3_trig || ch4_trig));

  assert_single_trig_R10: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> $onehot0({ch1_trig, ch2_trig, ch3_trig, ch4_trig}));

endmodule

bind snd_reg_bank snd_reg_bank_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .ch_active (ch_active),
  .rdata     (rdata),
  .power_on  (power_on),
  .ch1_env   (ch1_env),
  .ch1_freq  (ch1_freq),
  .mix_vol   (mix_vol),
  .mix_pan   (mix_pan),
  .ch1_trig  (ch1_trig),
  .ch2_trig  (ch2_trig),
  .ch3_trig  (ch3_trig),
  .ch4_trig  (ch4_trig)
);

// File: tb/tb_snd_reg_bank.sv
module tb_snd_reg_bank;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  addr;
  logic        wr_en;
  logic [7:0]  wdata;
  logic        style_old;
  logic [3:0]  ch_active;
  logic [7:0]  rdata;
  logic        power_on;
  logic [6:0]  ch1_sweep;
  logic [1:0]  ch1_duty, ch2_duty, ch3_level;
  logic [5:0]  ch1_len, ch2_len, ch4_len;
  logic [7:0]  ch1_env, ch2_env, ch3_len, ch4_env, ch4_poly, mix_vol, mix_pan;
  logic [10:0] ch1_freq, ch2_freq, ch3_freq;
  logic        ch1_len_en, ch2_len_en, ch3_len_en, ch4_len_en, ch3_dac_en;
  logic        ch1_trig, ch2_trig, ch3_trig, ch4_trig;

  always #2.5 clk = ~clk;

  snd_reg_bank dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .style_old(style_old), .ch_active(ch_active), .rdata(rdata),
    .power_on(power_on), .ch1_sweep(ch1_sweep), .ch1_duty(ch1_duty),
    .ch1_len(ch1_len), .ch1_env(ch1_env), .ch1_freq(ch1_freq),
    .ch1_len_en(ch1_len_en), .ch1_trig(ch1_trig), .ch2_duty(ch2_duty),
    .ch2_len(ch2_len), .ch2_env(ch2_env), .ch2_freq(ch2_freq),
    .ch2_len_en(ch2_len_en), .ch2_trig(ch2_trig), .ch3_dac_en(ch3_dac_en),
    .ch3_len(ch3_len), .ch3_level(ch3_level), .ch3_freq(ch3_freq),
    .ch3_len_en(ch3_len_en), .ch3_trig(ch3_trig), .ch4_len(ch4_len),
    .ch4_env(ch4_env), .ch4_poly(ch4_poly), .ch4_len_en(ch4_len_en),
    .ch4_trig(ch4_trig), .mix_vol(mix_vol), .mix_pan(mix_pan)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  logic [7:0] mreg [20];
  logic       mpwr;
  logic [3:0] exp_trig;

  function automatic logic [7:0] m_mask(input int a);
    case (a)
      0: return 8'h80;  1, 5: return 8'h3F;  3, 7, 12, 10, 14: return 8'hFF;
      4, 8, 13, 17: return 8'hBF;  9: return 8'h7F;  11: return 8'h9F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_reset(input int a);
    case (a)
      0: return 8'h80;  1: return 8'hBF;  2, 3, 19: return 8'hF3;  5: return 8'h3F;
      4, 8, 13, 17: return 8'hBF;  9: return 8'h7F;  10, 14: return 8'hFF;
      11: return 8'h9F;  18: return 8'h77;  default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input int a);
    if (a < 20) return mreg[a] | m_mask(a);
    if (a == 20) return {mpwr, 3'b111, ch_active};
    return 8'hFF;
  endfunction

  function automatic logic [127:0] exp_fields();
    return {mpwr, mreg[0][6:0], mreg[1][7:6], mreg[1][5:0], mreg[2],
            mreg[4][2:0], mreg[3], mreg[4][6],
            mreg[5][7:6], mreg[5][5:0], mreg[6], mreg[8][2:0], mreg[7], mreg[8][6],
            mreg[9][7], mreg[10], mreg[11][6:5], mreg[13][2:0], mreg[12], mreg[13][6],
            mreg[14][5:0], mreg[15], mreg[16], mreg[17][6], mreg[18], mreg[19], 2'b00};
  endfunction

  function automatic logic [127:0] act_fields();
    return {power_on, ch1_sweep, ch1_duty, ch1_len, ch1_env, ch1_freq, ch1_len_en,
            ch2_duty, ch2_len, ch2_env, ch2_freq, ch2_len_en,
            ch3_dac_en, ch3_len, ch3_level, ch3_freq, ch3_len_en,
            ch4_len, ch4_env, ch4_poly, ch4_len_en, mix_vol, mix_pan, 2'b00};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    exp_trig = 4'b0000;
    if (a == 20) begin
      if (mpwr && !d[7]) for (int i = 0; i < 20; i++) mreg[i] = 8'h00;
      mpwr = d[7];
    end else if (a < 20) begin
      if (mpwr) begin
        mreg[a] = d;
        if (d[7]) begin
          if (a == 4)  exp_trig[0] = 1'b1;
          if (a == 8)  exp_trig[1] = 1'b1;
          if (a == 13) exp_trig[2] = 1'b1;
          if (a == 17) exp_trig[3] = 1'b1;
        end
      end else if (style_old) begin
        if (a == 10 || a == 14) mreg[a] = d;
        else if (a == 1 || a == 5) mreg[a] = d & 8'h3F;
      end
    end
  endtask

  // write, then check trigger pulse and all fields (R9/R10/R12 tags)
  task automatic do_write(input int a, input logic [7:0] d, input string req);
    @(negedge clk);
    addr = 5'(a); wdata = d; wr_en = 1'b1;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check({req, " trig R10"}, 128'({ch4_trig, ch3_trig, ch2_trig, ch1_trig}), 128'(exp_trig));
    check({req, " fields R12"}, act_fields(), exp_fields());
    @(negedge clk);
    check({req, " trig clears R10"}, 128'({ch4_trig, ch3_trig, ch2_trig, ch1_trig}), 128'(0));
  endtask

  task automatic do_read(input int a, input string req);
    @(negedge clk);
    addr = 5'(a);
    @(negedge clk);
    check({req, " read R11"}, 128'(rdata), 128'(m_read(a)));
  endtask

  initial begin
    rst = 1'b1; addr = '0; wr_en = 1'b0; wdata = '0; style_old = 1'b0; ch_active = 4'b0000;
    for (int i = 0; i < 20; i++) mreg[i] = m_reset(i);
    mpwr = 1'b1;
    exp_trig = '0;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 fields", act_fields(), exp_fields());
    do_read(0, "R1 sweep");
    do_read(18, "R1 volume");
    do_read(19, "R1 panning");
    do_read(20, "R1 master");
    ch_active = 4'b0001;
    do_read(20, "R4 master active");
    for (int a = 0; a < 20; a++) do_read(a, "R2 mask sweep");

    // R2/R3 directed
    do_write(2, 8'h5A, "R2 env");       do_read(2, "R2 env");
    do_write(11, 8'h20, "R2 level");    do_read(11, "R2 level");
    do_write(3, 8'h12, "R3 flo");       do_read(3, "R3 flo");
    do_write(4, 8'h45, "R3 fhi");       do_read(4, "R3 fhi");
    do_write(4, 8'h05, "R3 fhi lenoff"); do_read(4, "R3 fhi lenoff");
    do_write(10, 8'h33, "R3 c3len");    do_read(10, "R3 c3len");

    // R10 triggers on each channel
    do_write(4, 8'hC2, "R10 ch1");
    do_write(8, 8'h81, "R10 ch2");
    do_write(13, 8'hC7, "R10 ch3");
    do_write(17, 8'h80, "R10 ch4");

    // R9 unmapped
    do_write(25, 8'hAA, "R9 wr");       do_read(25, "R9 rd");
    do_write(31, 8'h00, "R9 wr hi");    do_read(31, "R9 rd hi");

    // R4 master keeps bit 7 only
    do_write(20, 8'hFF, "R4 master");   do_read(20, "R4 master");

    // R5 power fall clears
    do_write(18, 8'h66, "R5 prep");
    do_write(20, 8'h7F, "R5 fall");
    for (int a = 0; a < 21; a++) do_read(a, "R5 cleared");

    // R6 power off, new style
    do_write(18, 8'h55, "R6 vol off");  do_read(18, "R6 vol off");
    do_write(1, 8'hFF, "R6 dl off");    do_read(1, "R6 dl off");
    do_write(10, 8'h77, "R6 c3len off");
    do_write(4, 8'hFF, "R6 trig off");

    // R7/R8 power off, older style
    style_old = 1'b1;
    do_write(10, 8'hAB, "R7 c3len");    do_read(10, "R7 c3len");
    do_write(14, 8'h2C, "R7 c4len");    do_read(14, "R7 c4len");
    do_write(1, 8'hFF, "R8 c1dl");      do_read(1, "R8 c1dl");
    do_write(5, 8'hC9, "R8 c2dl");      do_read(5, "R8 c2dl");
    do_write(19, 8'hEE, "R6 pan off old");

    // power back on: values kept
    do_write(20, 8'h80, "R4 power on");
    do_read(20, "R4 power on");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int a;
      logic [7:0] d;
      a = ($urandom % 8 == 0) ? 20 : int'($urandom % 32);
      d = 8'($urandom);
      if ($urandom % 16 == 0) style_old = ~style_old;
      ch_active = 4'($urandom);
      if (a == 20 && !mpwr) d[7] = ($urandom % 2 == 0);
      do_write(a, d, "R2 random");
      do_read(int'($urandom % 32), "R2 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R11 actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule